// File: doc/BRIEF.md
# Word-parallel Montgomery multiplier array with pipelined quotients

This block performs the iteration phase of a high-radix Montgomery multiplication. The operands are split into N words of K bits, and each word position has its own processing element (PE). At start, every PE captures one word of the multiplicand A and one word of the precomputed modulus constant M'. The multiplier B then enters one K-bit word per accepted cycle, least significant word first. Each round, every PE forms q·m'_j + b·a_j through three register stages. A fourth stage folds that product into the PE's running sum.

The quotient digit is the low word of PE 0. It goes back to all PEs through the same three-stage path, so each round uses the quotient from three rounds earlier. The first three quotient digits are zero seeds. With these two choices, no carry has to cross a PE boundary within a cycle, and the array finishes a multiplication in N+8 cycles.

The result is left in redundant form: one K-bit sum word and one (K+1)-bit carry word per PE. A separate stage converts this to plain binary. That stage, and the computation of M', are done outside this block.

Top module: `mmq_array`

## Requirements
- R1: While rst_n is low, and right after it falls (the reset is asynchronous), busy and done are 0 and every bit of sum_vec and carry_vec is 0.
- R2: When start is high while the block is idle, the block latches a_vec and mp_vec at that edge and clears all sum, carry, product and quotient registers. Later changes on a_vec and mp_vec have no effect. A result never depends on the previous multiplication.
- R3: If b_valid is high for the first N rounds, done is high in the cycle after the (N+7)th rising edge that follows the edge sampling start. busy is high from that start edge until done. done lasts exactly one cycle, and busy is low while done is high.
- R4: During the first N rounds, a cycle with b_valid low advances nothing. Each such cycle delays done by one cycle and leaves the result unchanged. Words of b_word are taken least significant first, one per accepted cycle.
- R5: The output value V = sum over j of 2^(K·j)·(s_j + 2^K·c_j) follows a fixed recurrence. Here s_j is sum_vec[K·j +: K] and c_j is carry_vec[(K+1)·j +: K+1]. The recurrence is V_(i+1) = floor(V_i / 2^K) + q_(i-3)·M' + b_i·A for i = 0 to N+3, starting from V_0 = 0. The quotient is q_i = V_i mod 2^K, the seeds q_-3, q_-2 and q_-1 are 0, and b_i = 0 for i ≥ N.
- R6: Carries never cross PEs. In each round, PE j computes r = q·m'_j + b·a_j + c_j + s_(j+1), with s_N taken as 0. It stores r mod 2^K as its new s_j and bits 2K..K of r as its new c_j.
- R7: During the last N+7-N rounds (rounds N to N+6), b_valid and b_word are ignored. The rounds advance every cycle and use a zero b word.
- R8: start is ignored while busy is high. It neither restarts the round count nor changes the result.
- R9: After done, sum_vec and carry_vec hold their values until the next accepted start, whatever b_valid, b_word, a_vec and mp_vec do.
- R10: All-ones operands never overflow the stage-4 adder or the (K+1)-bit carry word, and the result still obeys R5 and R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a multiplication when idle |
| b_valid | input | 1 | b_word carries the next multiplier word |
| b_word | input | K | Multiplier word, least significant first |
| a_vec | input | N·K | Multiplicand A, latched at start |
| mp_vec | input | N·K | Modulus constant M', latched at start |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| sum_vec | output | N·K | Per-PE sum words, PE j at bits K·j upward |
| carry_vec | output | N·(K+1) | Per-PE carry words, PE j at bits (K+1)·j upward |

## Verification
The bench builds the array with K = 8 and N = 4. At that size, all-ones operands push the carry words and the top bit of the stage-4 adder to their limits. Every result also fits a 128-bit integer, so the bench can check each multiplication two ways: word by word against the redundant per-PE rule, and as a whole value against the integer recurrence. Four PEs are enough for nonzero quotients to go round the loop several times, so stalls, late-round garbage on the b input and ignored starts all shift or corrupt visible results if mishandled.

// File: rtl/mmq_pkg.sv
package mmq_pkg;

  // rounds between a quotient leaving PE 0 and its use in stage 4
  localparam int unsigned QDELAY = 3;

  // register stages in front of the accumulate stage
  localparam int unsigned FILL = 3;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mmq_state_e;

  // rounds per multiplication: n operand words plus the quotient tail
  // plus the pipeline fill
  function automatic int unsigned mmq_rounds(input int unsigned n);
    return n + QDELAY + 1 + FILL;
  endfunction

endpackage

// File: rtl/mmq_csa3.sv
module mmq_csa3 #(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] total
);

  logic [W-1:0] part_sum;
  logic [W-1:0] part_cy;

  // one level of 3:2 compression, then a single carry-propagate add
  always_comb begin
    part_sum = x ^ y ^ z;
    part_cy  = ((x & y) | (x & z) | (y & z)) << 1;
    total    = part_sum + part_cy;
  end

endmodule

// File: rtl/mmq_ctrl.sv
module mmq_ctrl
  import mmq_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic b_valid,
  output logic clr,
  output logic adv,
  output logic feed,
  output logic busy,
  output logic done
);

  localparam int unsigned NR  = mmq_rounds(N);
  localparam int unsigned RCW = $clog2(NR + 1);
  localparam logic [RCW-1:0] LAST  = RCW'(NR - 1);
  localparam logic [RCW-1:0] FEEDN = RCW'(N);

  mmq_state_e     state_q, state_n;
  logic [RCW-1:0] round_q, round_n;
  logic           done_q, done_n;
  logic           last;

  always_comb begin
    clr     = (state_q == ST_IDLE) && start;
    feed    = (state_q == ST_RUN) && (round_q < FEEDN);
    adv     = (state_q == ST_RUN) && (!feed || b_valid);
    last    = (round_q == LAST);
    state_n = state_q;
    round_n = round_q;
    done_n  = 1'b0;
    if (clr) begin
      state_n = ST_RUN;
      round_n = '0;
    end else if (adv) begin
      round_n = RCW'(round_q + 1'b1);
      if (last) begin
        state_n = ST_IDLE;
        done_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      round_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      round_q <= round_n;
      done_q  <= done_n;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_round_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (round_q <= LAST));

  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv) |=> (busy && $stable(round_q)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && adv && !last) |=> (round_q == $past(round_q) + 1'b1));

endmodule

// File: rtl/mmq_pe.sv
module mmq_pe #(
  parameter int unsigned K = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         adv,
  input  logic [K-1:0] a_in,
  input  logic [K-1:0] m_in,
  input  logic [K-1:0] b_bc,
  input  logic [K-1:0] q_bc,
  input  logic [K-1:0] s_up,
  output logic [K-1:0] s_out,
  output logic [K:0]   c_out
);

  localparam int unsigned PW = 2 * K;
  localparam int unsigned WW = 2 * K + 1;
  localparam int unsigned RW = 2 * K + 2;

  logic [K-1:0]  a_q, a_n;
  logic [K-1:0]  m_q, m_n;
  logic [PW-1:0] pqm_q, pqm_n;
  logic [PW-1:0] pba_q, pba_n;
  logic [WW-1:0] w_q, w_n;
  logic [K-1:0]  s_q, s_n;
  logic [K:0]    c_q, c_n;
  logic [RW-1:0] acc;

  // stage 4: product word + own carry word + neighbour's sum word
  mmq_csa3 #(.W(RW)) u_csa (
    .x     (RW'(w_q)),
    .y     (RW'(c_q)),
    .z     (RW'(s_up)),
    .total (acc)
  );

  always_comb begin
    a_n   = a_q;
    m_n   = m_q;
    pqm_n = pqm_q;
    pba_n = pba_q;
    w_n   = w_q;
    s_n   = s_q;
    c_n   = c_q;
    if (clr) begin
      a_n   = a_in;
      m_n   = m_in;
      pqm_n = '0;
      pba_n = '0;
      w_n   = '0;
      s_n   = '0;
      c_n   = '0;
    end else if (adv) begin
      pqm_n = PW'(q_bc) * PW'(m_q);
      pba_n = PW'(b_bc) * PW'(a_q);
      w_n   = WW'(pqm_q) + WW'(pba_q);
      s_n   = acc[K-1:0];
      c_n   = acc[WW-1:K];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q   <= '0;
      m_q   <= '0;
      pqm_q <= '0;
      pba_q <= '0;
      w_q   <= '0;
      s_q   <= '0;
      c_q   <= '0;
    end else begin
      a_q   <= a_n;
      m_q   <= m_n;
      pqm_q <= pqm_n;
      pba_q <= pba_n;
      w_q   <= w_n;
      s_q   <= s_n;
      c_q   <= c_n;
    end
  end

  assign s_out = s_q;
  assign c_out = c_q;

  assert_acc_fits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> !acc[RW-1]);

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (s_q == '0 && c_q == '0 && w_q == '0));

endmodule

// File: rtl/mmq_array.sv
module mmq_array
  import mmq_pkg::*;
#(
  parameter int unsigned K = 16,
  parameter int unsigned N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               b_valid,
  input  logic [K-1:0]       b_word,
  input  logic [N*K-1:0]     a_vec,
  input  logic [N*K-1:0]     mp_vec,
  output logic               busy,
  output logic               done,
  output logic [N*K-1:0]     sum_vec,
  output logic [N*(K+1)-1:0] carry_vec
);

  logic clr, adv, feed;

  logic [K-1:0] b_q, b_n;
  logic [K-1:0] q_q, q_n;
  logic [K-1:0] s_w [N+1];
  logic [K:0]   c_w [N];

  mmq_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .b_valid (b_valid),
    .clr     (clr),
    .adv     (adv),
    .feed    (feed),
    .busy    (busy),
    .done    (done)
  );

  // stage 1: broadcast operand word and quotient digit to all PEs
  always_comb begin
    b_n = b_q;
    q_n = q_q;
    if (clr) begin
      b_n = '0;
      q_n = '0;
    end else if (adv) begin
      b_n = feed ? b_word : '0;
      q_n = s_w[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      q_q <= '0;
    end else begin
      b_q <= b_n;
      q_q <= q_n;
    end
  end

  assign s_w[N] = '0;

  for (genvar j = 0; j < N; j++) begin : g_pe
    mmq_pe #(.K(K)) u_pe (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .adv   (adv),
      .a_in  (a_vec[j*K +: K]),
      .m_in  (mp_vec[j*K +: K]),
      .b_bc  (b_q),
      .q_bc  (q_q),
      .s_up  (s_w[j+1]),
      .s_out (s_w[j]),
      .c_out (c_w[j])
    );
    assign sum_vec[j*K +: K]         = s_w[j];
    assign carry_vec[j*(K+1) +: K+1] = c_w[j];
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum_vec) && $stable(carry_vec)));

  assert_late_word_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !feed && adv) |=> (b_q == '0));

endmodule

// File: tb/mmq_array_bench.sv
`timescale 1ns/1ps
module mmq_array_bench;

  localparam int unsigned K  = 8;
  localparam int unsigned N  = 4;
  localparam int unsigned NK = N * K;
  localparam int unsigned CW = N * (K + 1);
  localparam int unsigned RW = 2 * K + 2;
  localparam int unsigned NV = 6;

  localparam logic [NK-1:0] VA [NV] = '{32'h00000001, 32'h12345678, 32'hffffffff,
                                        32'h00000000, 32'h80000001, 32'h0000ff00};
  localparam logic [NK-1:0] VM [NV] = '{32'h00000000, 32'h9abcdef1, 32'hffffffff,
                                        32'hdeadbeef, 32'h7fffffff, 32'h01020304};
  localparam logic [NK-1:0] VB [NV] = '{32'h00000001, 32'h0badf00d, 32'hffffffff,
                                        32'h11111111, 32'h00000080, 32'hffff0000};

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          b_valid;
  logic [K-1:0]  b_word;
  logic [NK-1:0] a_vec;
  logic [NK-1:0] mp_vec;
  logic          busy;
  logic          done;
  logic [NK-1:0] sum_vec;
  logic [CW-1:0] carry_vec;

  int total = 0;
  int bad   = 0;

  logic [127:0]  exp_val;
  logic [NK-1:0] exp_sum;
  logic [CW-1:0] exp_carry;

  mmq_array #(.K(K), .N(N)) u_mmq_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .b_valid   (b_valid),
    .b_word    (b_word),
    .a_vec     (a_vec),
    .mp_vec    (mp_vec),
    .busy      (busy),
    .done      (done),
    .sum_vec   (sum_vec),
    .carry_vec (carry_vec)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  // reference: integer recurrence and word-wise redundant rule
  task automatic model(input logic [NK-1:0] a, input logic [NK-1:0] m,
                       input logic [NK-1:0] b);
    logic [127:0]  v;
    logic [K-1:0]  qh [N+4];
    logic [K-1:0]  qd;
    logic [K-1:0]  bi;
    logic [K-1:0]  s [N+1];
    logic [K:0]    c [N];
    logic [K-1:0]  s_nx [N];
    logic [K:0]    c_nx [N];
    logic [RW-1:0] r;
    v = '0;
    for (int j = 0; j <= N; j++) s[j] = '0;
    for (int j = 0; j < N; j++) c[j] = '0;
    for (int i = 0; i < N + 4; i++) begin
      qh[i] = v[K-1:0];
      qd = '0;
      if (i >= 3) qd = qh[i-3];
      bi = '0;
      if (i < N) bi = b[i*K +: K];
      v = (v >> K) + 128'(qd) * 128'(m) + 128'(bi) * 128'(a);
      for (int j = 0; j < N; j++) begin
        r = RW'(qd) * RW'(m[j*K +: K]) + RW'(bi) * RW'(a[j*K +: K])
          + RW'(c[j]) + RW'(s[j+1]);
        s_nx[j] = r[K-1:0];
        c_nx[j] = r[2*K:K];
      end
      for (int j = 0; j < N; j++) begin
        s[j] = s_nx[j];
        c[j] = c_nx[j];
      end
    end
    exp_val = v;
    for (int j = 0; j < N; j++) begin
      exp_sum[j*K +: K]           = s[j];
      exp_carry[j*(K+1) +: K+1]   = c[j];
    end
  endtask

  function automatic logic [127:0] out_val();
    logic [127:0] v;
    v = '0;
    for (int j = 0; j < N; j++)
      v = v + ((128'(sum_vec[j*K +: K]) + (128'(carry_vec[j*(K+1) +: K+1]) << K)) << (K * j));
    return v;
  endfunction

  task automatic run(input logic [NK-1:0] a, input logic [NK-1:0] m,
                     input logic [NK-1:0] b, input logic [31:0] stall,
                     input bit junk, input bit midstart, input string req);
    int  stalls = 0;
    int  wi = 0;
    int  cyc = 0;
    int  done_at = 0;
    bit  busy_ok = 1'b1;
    a_vec   = a;
    mp_vec  = m;
    start   = 1'b1;
    b_valid = 1'b0;
    @(posedge clk); #1;
    start  = 1'b0;
    a_vec  = ~a;   // latched at start; must not matter now (R2)
    mp_vec = ~m;
    while (done_at == 0 && cyc < 64) begin
      cyc++;
      if (wi < N && stall[cyc]) begin
        b_valid = 1'b0;
        b_word  = 8'h5a;
        stalls++;
      end else if (wi < N) begin
        b_valid = 1'b1;
        b_word  = b[wi*K +: K];
        wi++;
      end else begin
        b_valid = junk;
        b_word  = junk ? 8'hc3 : 8'h00;
      end
      start = midstart && (cyc == 5);
      @(posedge clk); #1;
      if (done) done_at = cyc;
      else if (!busy) busy_ok = 1'b0;
    end
    start   = 1'b0;
    b_valid = 1'b0;
    model(a, m, b);
    chk(done_at == N + 7 + stalls, req, "R3 done edge", 128'(done_at), 128'(N + 7 + stalls));
    chk(busy_ok, req, "R3 busy until done", 128'(busy_ok), 128'd1);
    chk(sum_vec == exp_sum, req, "R6 sum words", 128'(sum_vec), 128'(exp_sum));
    chk(carry_vec == exp_carry, req, "R6 carry words", 128'(carry_vec), 128'(exp_carry));
    chk(out_val() == exp_val, req, "R5 value", out_val(), exp_val);
    @(posedge clk); #1;
    chk(!done, req, "R3 done one cycle", 128'(done), 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start   = 1'b0;
    b_valid = 1'b0;
    b_word  = '0;
    a_vec   = '0;
    mp_vec  = '0;
    repeat (3) @(posedge clk); #1;
    chk(!busy && !done, "R1", "flags in reset", 128'({busy, done}), 128'd0);
    chk(sum_vec == '0 && carry_vec == '0, "R1", "outputs in reset",
        128'(sum_vec) | 128'(carry_vec), 128'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!busy && !done && sum_vec == '0, "R1", "after release", 128'({busy, done}), 128'd0);

    // table walk, back to back (R2: no state carried between runs)
    for (int v = 0; v < NV; v++) begin
      run(VA[v], VM[v], VB[v], 32'h0, 1'b0, 1'b0, "R5");
      if (v == 3)
        chk(out_val() == '0, "R2", "zero A after all-ones run", out_val(), 128'd0);
      if (v == 2)
        chk(carry_vec == exp_carry, "R10", "all-ones carry words", 128'(carry_vec), 128'(exp_carry));
    end

    // stalls during the feed rounds (R4)
    run(32'h12345678, 32'h9abcdef1, 32'h0badf00d, 32'h0000002c, 1'b0, 1'b0, "R4");

    // garbage on the b input after the feed rounds (R7)
    run(32'hcafe0123, 32'h55aa33cc, 32'h76543210, 32'h0, 1'b1, 1'b0, "R7");

    // start pulsed mid-run (R8)
    run(32'hffffffff, 32'h01010101, 32'h80808080, 32'h0, 1'b0, 1'b1, "R8");

    // outputs hold after done (R9)
    model(32'hffffffff, 32'h01010101, 32'h80808080);
    b_valid = 1'b1;
    b_word  = 8'hff;
    a_vec   = 32'h0f0f0f0f;
    mp_vec  = 32'hf0f0f0f0;
    repeat (5) @(posedge clk); #1;
    chk(sum_vec == exp_sum && carry_vec == exp_carry, "R9", "hold after done",
        128'(sum_vec), 128'(exp_sum));
    b_valid = 1'b0;

    // asynchronous reset in mid-run (R1)
    a_vec  = 32'h13572468;
    mp_vec = 32'h24681357;
    start  = 1'b1;
    @(posedge clk); #1;
    start   = 1'b0;
    b_valid = 1'b1;
    b_word  = 8'h77;
    repeat (6) @(posedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    chk(!busy && !done, "R1", "flags after mid-run reset", 128'({busy, done}), 128'd0);
    chk(sum_vec == '0 && carry_vec == '0, "R1", "outputs after mid-run reset",
        128'(sum_vec) | 128'(carry_vec), 128'd0);
    b_valid = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // clean run after reset
    run(32'hdeadbeef, 32'h0badcafe, 32'h00ff00ff, 32'h0, 1'b0, 1'b0, "R5");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule